// File: doc/BRIEF.md
# Multi-User Inter-Processor Mailbox

This block lets several processors exchange 32-bit messages through a set of hardware FIFOs placed on a simple memory-mapped register bus. A producer writes a word to a FIFO's message register to enqueue it, and a consumer reads the same register to dequeue the oldest word. Each FIFO has two read-only registers. One reports whether the FIFO is full. The other reports how many words are waiting.

Every FIFO produces two events. A "new message" event fires when a word is accepted. A "not full" event fires when a read frees a slot in a FIFO that was full. Both events are latched into a sticky status register belonging to each interrupt user. A user clears its status bits by writing ones to them. Each user also has an enable mask, which it changes through separate set and clear registers. The user's level interrupt output is high while any enabled status bit is set.

The bus carries single-cycle accesses. Read data is combinational from the current state. A dequeue or register update takes effect at the clock edge that ends the access.

Top module: `mbox_hub`

## Requirements
- R1: A read of offset 0x000 returns the REVISION parameter. Writes to it have no effect.
- R2: Offset 0x040 + 4*m is FIFO m's message register. A write enqueues the 32-bit write data. A read returns the oldest word and removes it, so words come out in the order they were written.
- R3: Offset 0x080 + 4*m reads 1 when FIFO m holds DEPTH words and 0 otherwise.
- R4: Offset 0x0C0 + 4*m reads the number of words held in FIFO m, from 0 to DEPTH.
- R5: A write to a full FIFO is discarded and leaves the FIFO unchanged. A read of an empty FIFO returns 0 and changes nothing.
- R6: In every user's status register, bit 2*m is set when a write to FIFO m is accepted. This happens for all users, whatever their enable masks.
- R7: In every user's status register, bit 2*m+1 is set when a read removes a word from FIFO m while that FIFO was full.
- R8: User u's status register is at 0x104 + 0x10*u. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A read returns the current value.
- R9: User u's enable-set register is at 0x108 + 0x10*u and its enable-clear register is at 0x10C + 0x10*u. Writing 1 to a bit enables or disables that event. Reading either register returns the enable mask, which uses the same bit layout as the status register.
- R10: irqOut[u] is high exactly when status AND enable of user u is nonzero. It reflects register updates in the cycle after the access.
- R11: A read of an unmapped offset returns 0, and a write to one changes no state. Unmapped offsets include misaligned addresses, FIFO indices at or above NUM_FIFOS, and user indices at or above NUM_USERS.
- R12: Reset empties all FIFOs and clears every status and enable bit, so all interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| irqOut | output | NUM_USERS | Level interrupt, one per user |

## Verification
The bench builds the block with four FIFOs, three users and a depth of four. At this size random traffic regularly fills FIFOs to the brim and drains them dry. That brings the dropped write, the empty read and the full-to-not-full event into frequent reach. Three users are enough to show that status bits latch in every user's bank while the enable masks and interrupts stay separate. The fourth user slot (offset 0x134) and the fifth FIFO slot (offset 0x050) fall into unmapped space, so the index bound checks are exercised too.

// File: rtl/mbox_hub_pkg.sv
package mbox_hub_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int FSEL_W   = 4;   // up to 16 FIFOs

  // Strobes from the control side into the FIFO datapath
  typedef struct packed {
    logic              push;
    logic              pop;
    logic [FSEL_W-1:0] sel;
    logic [DATA_W-1:0] data;
  } fifoStrobe_t;
endpackage

// File: rtl/mbox_hub_fifos.sv
module mbox_hub_fifos
  import mbox_hub_pkg::*;
#(
  parameter int NUM_FIFOS = 8,
  parameter int DEPTH     = 4,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  fifoStrobe_t                        stb,
  output logic [NUM_FIFOS-1:0][CW-1:0]       fifoCount,
  output logic [NUM_FIFOS-1:0][DATA_W-1:0]   fifoHead
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wrPtr, rdPtr;
    logic [CW-1:0]     cnt;
    logic              hit, doPush, doPop;

    assign hit    = (int'(stb.sel) == m);
    assign doPush = hit && stb.push && (cnt < CW'(DEPTH));
    assign doPop  = hit && stb.pop  && (cnt != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (doPush) begin
          wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
          cnt   <= cnt + 1'b1;
        end
        if (doPop) begin
          rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
          cnt   <= cnt - 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= stb.data;
    end

    assign fifoCount[m] = cnt;
    assign fifoHead[m]  = mem[rdPtr];
  end
endmodule

// File: rtl/mbox_hub_ctl.sv
module mbox_hub_ctl
  import mbox_hub_pkg::*;
#(
  parameter int          NUM_FIFOS = 8,
  parameter int          NUM_USERS = 4,
  parameter int          DEPTH     = 4,
  parameter logic [31:0] REVISION  = 32'h0001_0200,
  parameter int          CW        = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busSel,
  input  logic                              busWr,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [DATA_W-1:0]                 busWdata,
  output logic [DATA_W-1:0]                 busRdata,
  output logic [NUM_USERS-1:0]              irqOut,
  output fifoStrobe_t                       stb,
  input  logic [NUM_FIFOS-1:0][CW-1:0]      fifoCount,
  input  logic [NUM_FIFOS-1:0][DATA_W-1:0]  fifoHead
);
  localparam int SW = 2 * NUM_FIFOS;

  logic                aligned, fifoRange, userRange;
  logic [1:0]          fifoKind;   // 1 msg, 2 full, 3 count
  logic [1:0]          userKind;   // 1 status, 2 set, 3 clear
  int                  fIdx, uIdx;
  logic                fHit, uHit;
  logic [NUM_USERS-1:0] wrStat, wrSet, wrClr;
  logic [SW-1:0]       evVec;
  logic [NUM_USERS-1:0][SW-1:0] stReg, enReg;

  // Address decode
  always_comb begin
    aligned   = (busAddr[1:0] == 2'b00);
    fIdx      = int'(busAddr[5:2]);
    uIdx      = int'(busAddr[7:4]);
    fifoKind  = busAddr[7:6];
    userKind  = busAddr[3:2];
    fifoRange = aligned && (busAddr[11:8] == 4'h0) && (fifoKind != 2'd0);
    userRange = aligned && (busAddr[11:8] == 4'h1) && (userKind != 2'd0);
    fHit      = fifoRange && (fIdx < NUM_FIFOS);
    uHit      = userRange && (uIdx < NUM_USERS);

    stb       = '0;
    stb.sel   = busAddr[5:2];
    stb.data  = busWdata;
    stb.push  = busSel &&  busWr && fHit && (fifoKind == 2'd1);
    stb.pop   = busSel && !busWr && fHit && (fifoKind == 2'd1);

    for (int u = 0; u < NUM_USERS; u++) begin
      wrStat[u] = busSel && busWr && uHit && (uIdx == u) && (userKind == 2'd1);
      wrSet[u]  = busSel && busWr && uHit && (uIdx == u) && (userKind == 2'd2);
      wrClr[u]  = busSel && busWr && uHit && (uIdx == u) && (userKind == 2'd3);
    end
  end

  // Event generation from the strobes and the occupancy before the edge
  always_comb begin
    evVec = '0;
    for (int m = 0; m < NUM_FIFOS; m++) begin
      if (int'(stb.sel) == m) begin
        evVec[2*m]   = stb.push && (fifoCount[m] < CW'(DEPTH));
        evVec[2*m+1] = stb.pop  && (fifoCount[m] == CW'(DEPTH));
      end
    end
  end

  // Per-user sticky status and enable masks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stReg <= '0;
      enReg <= '0;
    end else begin
      for (int u = 0; u < NUM_USERS; u++) begin
        stReg[u] <= (stReg[u] & ~(wrStat[u] ? busWdata[SW-1:0] : '0)) | evVec;
        if (wrSet[u]) enReg[u] <= enReg[u] | busWdata[SW-1:0];
        else if (wrClr[u]) enReg[u] <= enReg[u] & ~busWdata[SW-1:0];
      end
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_USERS; u++) irqOut[u] = |(stReg[u] & enReg[u]);
  end

  // Read mux
  always_comb begin
    busRdata = '0;
    if (aligned && busAddr == '0) busRdata = REVISION;
    for (int m = 0; m < NUM_FIFOS; m++) begin
      if (fHit && fIdx == m) begin
        unique case (fifoKind)
          2'd1: busRdata = (fifoCount[m] != '0) ? fifoHead[m] : '0;
          2'd2: busRdata = {31'b0, fifoCount[m] == CW'(DEPTH)};
          2'd3: busRdata = 32'(fifoCount[m]);
          default: busRdata = '0;
        endcase
      end
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (uHit && uIdx == u) begin
        busRdata = (userKind == 2'd1) ? 32'(stReg[u]) : 32'(enReg[u]);
      end
    end
  end
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
  import mbox_hub_pkg::*;
#(
  parameter int          NUM_FIFOS = 8,
  parameter int          NUM_USERS = 4,
  parameter int          DEPTH     = 4,
  parameter logic [31:0] REVISION  = 32'h0001_0200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [11:0]          busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_USERS-1:0] irqOut
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobe_t                        stb;
  logic [NUM_FIFOS-1:0][CW-1:0]       fifoCount;
  logic [NUM_FIFOS-1:0][DATA_W-1:0]   fifoHead;

  mbox_hub_ctl #(
    .NUM_FIFOS(NUM_FIFOS), .NUM_USERS(NUM_USERS), .DEPTH(DEPTH),
    .REVISION(REVISION), .CW(CW)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .stb(stb), .fifoCount(fifoCount), .fifoHead(fifoHead)
  );

  mbox_hub_fifos #(
    .NUM_FIFOS(NUM_FIFOS), .DEPTH(DEPTH), .CW(CW)
  ) u_fifos (
    .clk(clk), .rstN(rstN), .stb(stb),
    .fifoCount(fifoCount), .fifoHead(fifoHead)
  );
endmodule

// File: rtl/mbox_hub_chk.sv
module mbox_hub_chk #(
  parameter int NUM_FIFOS = 8,
  parameter int NUM_USERS = 4,
  parameter int DEPTH     = 4,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          busSel,
  input logic                          busWr,
  input logic [11:0]                   busAddr,
  input logic [31:0]                   busWdata,
  input logic [NUM_USERS-1:0]          irqOut,
  input logic [NUM_FIFOS-1:0][CW-1:0]  fifoCount
);
  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_f
    localparam logic [11:0] MSG_A = 12'(32'h040 + 4 * m);

    // R4: occupancy never exceeds the depth
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
      fifoCount[m] <= CW'(DEPTH));

    // R5: a write to a full FIFO is discarded
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == MSG_A && fifoCount[m] == CW'(DEPTH))
      |=> fifoCount[m] == CW'(DEPTH));

    // R5: a read of an empty FIFO leaves it empty
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && !busWr && busAddr == MSG_A && fifoCount[m] == '0)
      |=> fifoCount[m] == '0);

    // R2: an accepted write adds exactly one word
    p_push_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == MSG_A && fifoCount[m] < CW'(DEPTH))
      |=> fifoCount[m] == $past(fifoCount[m]) + 1'b1);
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
    localparam logic [11:0] CLR_A = 12'(32'h10C + 16 * u);

    // R10: clearing the whole enable mask drops the interrupt next cycle
    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == CLR_A && busWdata == 32'hFFFF_FFFF)
      |=> !irqOut[u]);
  end
endmodule

bind mbox_hub mbox_hub_chk #(
  .NUM_FIFOS(NUM_FIFOS), .NUM_USERS(NUM_USERS), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .irqOut(irqOut),
  .fifoCount(fifoCount)
);

// File: tb/mbox_hub_tb.sv
`timescale 1ns/1ps
module mbox_hub_tb;
  localparam int          NF  = 4;
  localparam int          NU  = 3;
  localparam int          D   = 4;
  localparam int          SW  = 2 * NF;
  localparam logic [31:0] REV = 32'hC0DE_0107;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWr = 1'b0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NU-1:0] irqOut;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tagOverride = "";

  // reference model
  int            mCnt [NF];
  logic [31:0]   mMem [NF][D];
  logic [SW-1:0] mSt [NU];
  logic [SW-1:0] mEn [NU];

  always #2.5 clk = ~clk;

  mbox_hub #(.NUM_FIFOS(NF), .NUM_USERS(NU), .DEPTH(D), .REVISION(REV)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic void mdlReset();
    for (int f = 0; f < NF; f++) mCnt[f] = 0;
    for (int u = 0; u < NU; u++) begin mSt[u] = '0; mEn[u] = '0; end
  endfunction

  function automatic string reqOf(logic [11:0] a);
    int ai = int'(a);
    if (tagOverride != "") return tagOverride;
    if (a[1:0] != 2'b00) return "R11";
    if (ai == 0) return "R1";
    if (ai >= 'h40 && ai < 'h40 + 4*NF) return "R2 R5";
    if (ai >= 'h80 && ai < 'h80 + 4*NF) return "R3";
    if (ai >= 'hC0 && ai < 'hC0 + 4*NF) return "R4 R5";
    if (ai >= 'h100 && ai < 'h100 + 16*NU) begin
      if (a[3:2] == 2'd1) return "R6 R7 R8";
      if (a[3:2] != 2'd0) return "R9";
    end
    return "R11";
  endfunction

  // Applies one access to the model, returns expected read data
  function automatic logic [31:0] mdl(bit wr, logic [11:0] a, logic [31:0] d);
    logic [31:0]   r = '0;
    logic [SW-1:0] ev = '0;
    int ai = int'(a);
    if (a[1:0] == 2'b00) begin
      if (ai == 0) r = REV;
      else if (ai >= 'h40 && ai < 'h40 + 4*NF) begin
        int f = (ai - 'h40) / 4;
        if (wr) begin
          if (mCnt[f] < D) begin mMem[f][mCnt[f]] = d; mCnt[f]++; ev[2*f] = 1'b1; end
        end else if (mCnt[f] > 0) begin
          r = mMem[f][0];
          if (mCnt[f] == D) ev[2*f+1] = 1'b1;
          for (int k = 0; k < D-1; k++) mMem[f][k] = mMem[f][k+1];
          mCnt[f]--;
        end
      end
      else if (ai >= 'h80 && ai < 'h80 + 4*NF) r = (mCnt[(ai-'h80)/4] == D) ? 32'd1 : 32'd0;
      else if (ai >= 'hC0 && ai < 'hC0 + 4*NF) r = 32'(mCnt[(ai-'hC0)/4]);
      else if (ai >= 'h100 && ai < 'h100 + 16*NU && a[3:2] != 2'd0) begin
        int u = (ai - 'h100) / 16;
        case (a[3:2])
          2'd1: begin r = 32'(mSt[u]); if (wr) mSt[u] &= ~d[SW-1:0]; end
          2'd2: begin r = 32'(mEn[u]); if (wr) mEn[u] |= d[SW-1:0]; end
          default: begin r = 32'(mEn[u]); if (wr) mEn[u] &= ~d[SW-1:0]; end
        endcase
      end
    end
    for (int u = 0; u < NU; u++) mSt[u] |= ev;
    return wr ? 32'd0 : r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO-block check FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkIrq();
    logic [NU-1:0] e;
    for (int u = 0; u < NU; u++) e[u] = |(mSt[u] & mEn[u]);
    chk((tagOverride != "") ? tagOverride : "R10", 32'(irqOut), 32'(e));
  endtask

  task automatic access(bit wr, logic [11:0] a, logic [31:0] d);
    logic [31:0] exp;
    string tag;
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = a; busWdata = d;
    #1;
    tag = reqOf(a);
    exp = mdl(wr, a, d);
    if (!wr) chk(tag, busRdata, exp);
    @(posedge clk);
    #1;
    busSel = 1'b0; busWr = 1'b0;
    checkIrq();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busSel = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mdlReset();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FIFO-block check FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mdlReset();
    doReset();

    // R12: state after reset
    tagOverride = "R12";
    for (int f = 0; f < NF; f++) begin
      access(0, 12'(32'hC0 + 4*f), 0);
      access(0, 12'(32'h80 + 4*f), 0);
    end
    for (int u = 0; u < NU; u++) begin
      access(0, 12'(32'h104 + 16*u), 0);
      access(0, 12'(32'h108 + 16*u), 0);
    end
    tagOverride = "";

    // R1: revision, read-only
    access(0, 12'h000, 0);
    access(1, 12'h000, 32'h1234_5678);
    access(0, 12'h000, 0);

    // R2 R3 R5 R6: fill FIFO 1 past its depth
    for (int k = 0; k < D + 1; k++) access(1, 12'h044, 32'hA000_0000 + k);
    access(0, 12'h084, 0);
    access(0, 12'h0C4, 0);
    for (int u = 0; u < NU; u++) access(0, 12'(32'h104 + 16*u), 0);
    // R9 R10: enable new-message of FIFO 1 for user 1 only
    access(1, 12'h118, 32'h0000_0004);
    access(0, 12'h11C, 0);
    // R2 R7: drain in order, first read sets not-full
    for (int k = 0; k < D; k++) access(0, 12'h044, 0);
    access(0, 12'h044, 0);           // R5: empty read returns 0
    access(0, 12'h0C4, 0);
    access(0, 12'h114, 0);
    // R8: W1C with mixed ones and zeros
    access(1, 12'h114, 32'h0000_0004);
    access(0, 12'h114, 0);
    access(1, 12'h11C, 32'hFFFF_FFFF);
    access(0, 12'h118, 0);

    // R11: unmapped offsets
    access(1, 12'h050, 32'hDEAD_BEEF);
    access(0, 12'h050, 0);
    access(1, 12'h134, 32'hFF);
    access(0, 12'h134, 0);
    access(1, 12'h046, 32'h1);
    access(0, 12'h046, 0);
    access(1, 12'h100, 32'hFF);
    access(0, 12'h100, 0);
    access(0, 12'hC4C, 0);
    access(0, 12'h0C4, 0);

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom % 100;
      int f = $urandom % NF;
      int u = $urandom % NU;
      logic [31:0] d = $urandom;
      if (r < 35)      access(($urandom % 100) < 55, 12'(32'h40 + 4*f), d);
      else if (r < 42) access(0, 12'(32'h80 + 4*f), 0);
      else if (r < 50) access(0, 12'(32'hC0 + 4*f), 0);
      else if (r < 65) access($urandom % 2, 12'(32'h104 + 16*u), d);
      else if (r < 78) access($urandom % 2, 12'(32'h108 + 16*u), d & 32'h0000_00FF);
      else if (r < 88) access($urandom % 2, 12'(32'h10C + 16*u), d & 32'h0000_00FF);
      else if (r < 97) access($urandom % 2, 12'($urandom % 12'h140), d);
      else             access(0, 12'h000, 0);
      if (i == 900) begin
        // R12: reset mid-run after traffic
        doReset();
        tagOverride = "R12";
        access(0, 12'(32'hC0 + 4*f), 0);
        access(0, 12'(32'h104 + 16*u), 0);
        access(0, 12'(32'h108 + 16*u), 0);
        tagOverride = "";
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule